// File: doc/BRIEF.md
# Software Reset Request Register

This block is one 32-bit control register that lets software ask for a reset. A single-cycle register bus reaches it: an address, a write strobe, write data and combinational read data. Two bits of the register trigger actions when written with 1. One bit asks the chip's reset sequencer for an internal system reset. The other bit drives an external reset output pin for a fixed number of clock cycles and leaves the internal reset alone.

A single input, `otherRstSrc`, tells the block that some other reset source is active. That input cancels any request the block has pending and ends a running external pulse at the next clock edge. The external pulse is timed by a down-counter. The external bit reads back as 1 while its pulse runs and clears by itself when the pulse ends. The internal system reset bit always reads back as 0.

Top module: `swrst_ctl_reg`

## Requirements
- R1: While `rst_n` is low and right after it rises, `sysRstReq` and `extRstOut` are 0 and a read at the register offset returns 0.
- R2: The register answers only at address 0x10. A write to any other address has no effect, and a read at any other address returns 0.
- R3: Bits are numbered from the MSB. Bit 0 (the system bit) is data bit 31 and bit 1 (the external bit) is data bit 30. Read data bits 29..0 are always 0, and writes to bits 29..0 have no effect.
- R4: A write with data bit 31 set drives `sysRstReq` high for exactly the cycle after the write, once per such write. Read data bit 31 is always 0.
- R5: A write with data bit 30 set and bit 31 clear, made while no pulse is running, drives `extRstOut` high from the next cycle for exactly 2400 cycles. `sysRstReq` stays low.
- R6: Read data bit 30 equals 1 exactly while the external pulse is running and returns to 0 by itself when the pulse ends.
- R7: Writing 0 to either trigger bit has no effect on a pulse that is idle or running.
- R8: In any cycle where `otherRstSrc` is high, a running pulse ends (`extRstOut` low in the next cycle) and a write made in that same cycle starts nothing.
- R9: Writing the external bit again while a pulse runs neither restarts nor extends the pulse.
- R10: When bits 31 and 30 are written together, only the system reset is raised. A pulse that is already running is ended by that system request in the same edge that raises `sysRstReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register address |
| busWe | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address |
| otherRstSrc | input | 1 | High while any other reset source is active |
| sysRstReq | output | 1 | Internal system reset request, one-cycle pulse |
| extRstOut | output | 1 | External reset output, active high |

## Verification
The external pulse can overlap a system-reset write or an assertion of `otherRstSrc`, and both trigger bits can arrive in one write. The bench sets up each of these overlaps on purpose. It writes both bits while the pulse is idle and again while it runs, and it raises `otherRstSrc` in the same cycle as a system-bit write in the middle of a pulse. A behavioural model is compared against the design every cycle and judges the result: the model predicts which request wins and the exact edge on which the pulse output drops.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  // Bit positions counted from the MSB of the data word.
  localparam int SYS_POS = 0;
  localparam int EXT_POS = 1;

  typedef struct packed {
    logic fireSys;
    logic loadPulse;
    logic abortPulse;
  } swrst_strobe_t;

endpackage

// File: rtl/swrst_ctl_decode.sv
module swrst_ctl_decode
  import swrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              otherRstSrc,
  input  logic              extBusy,
  output swrst_strobe_t     strb,
  output logic [DATA_W-1:0] busRdata
);

  localparam int SYS_IDX = DATA_W - 1 - SYS_POS;
  localparam int EXT_IDX = DATA_W - 1 - EXT_POS;

  logic addrHit;
  logic wrHit;
  logic sysBit;
  logic extBit;

  assign addrHit = (busAddr == REG_OFFSET);
  assign wrHit   = busWe && addrHit;
  assign sysBit  = busWdata[SYS_IDX];
  assign extBit  = busWdata[EXT_IDX];

  always_comb begin
    strb = '0;
    // Another reset source cancels everything written in this cycle.
    strb.fireSys    = wrHit && sysBit && !otherRstSrc;
    // System request wins over a same-cycle external request; a running
    // pulse is never reloaded.
    strb.loadPulse  = wrHit && extBit && !sysBit && !otherRstSrc && !extBusy;
    strb.abortPulse = otherRstSrc || strb.fireSys;
  end

  always_comb begin
    busRdata = '0;
    if (addrHit) busRdata[EXT_IDX] = extBusy;
  end

endmodule

// File: rtl/swrst_ctl_datapath.sv
module swrst_ctl_datapath
  import swrst_pkg::*;
#(
  parameter int PULSE_LEN = 2400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  swrst_strobe_t strb,
  output logic          sysRstReq,
  output logic          extRstOut
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

  logic [CNT_W-1:0] remCnt;
  logic             extQ;
  logic             sysQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remCnt <= '0;
      extQ   <= 1'b0;
      sysQ   <= 1'b0;
    end else begin
      sysQ <= strb.fireSys;
      if (strb.abortPulse) begin
        remCnt <= '0;
        extQ   <= 1'b0;
      end else if (strb.loadPulse) begin
        remCnt <= LOAD_VAL;
        extQ   <= 1'b1;
      end else if (remCnt != '0) begin
        remCnt <= remCnt - LAST_VAL;
        if (remCnt == LAST_VAL) extQ <= 1'b0;
      end
    end
  end

  assign sysRstReq = sysQ;
  assign extRstOut = extQ;

endmodule

// File: rtl/swrst_ctl_reg.sv
module swrst_ctl_reg
  import swrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
  parameter int PULSE_LEN = 2400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              otherRstSrc,
  output logic              sysRstReq,
  output logic              extRstOut
);

  swrst_strobe_t strb;

  swrst_ctl_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
  ) u_decode (
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .otherRstSrc(otherRstSrc), .extBusy(extRstOut),
    .strb(strb), .busRdata(busRdata)
  );

  swrst_ctl_datapath #(
    .PULSE_LEN(PULSE_LEN)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .sysRstReq(sysRstReq), .extRstOut(extRstOut)
  );

endmodule

// File: rtl/swrst_ctl_reg_chk.sv
module swrst_ctl_reg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
  parameter int PULSE_LEN = 2400
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              otherRstSrc,
  input logic              sysRstReq,
  input logic              extRstOut
);

  localparam int RUN_W = $clog2(PULSE_LEN + 1) + 1;

  logic sysWr;
  logic extWr;
  logic [RUN_W-1:0] runLen;

  assign sysWr = busWe && (busAddr == REG_OFFSET) && busWdata[DATA_W-1];
  assign extWr = busWe && (busAddr == REG_OFFSET) && busWdata[DATA_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runLen <= '0;
    else if (extRstOut) runLen <= runLen + RUN_W'(1);
    else runLen <= '0;
  end

  // R4
  sys_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sysWr && !otherRstSrc) |=> sysRstReq);

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otherRstSrc |=> (!extRstOut && !sysRstReq));

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (extWr && !sysWr && !otherRstSrc && !extRstOut) |=> (extRstOut && !sysRstReq));

  // R9
  pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runLen <= RUN_W'(PULSE_LEN));

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(extRstOut) && !$past(otherRstSrc) && !$past(sysWr))
      |-> (runLen == RUN_W'(PULSE_LEN)));

  // R10
  sys_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sysWr && extWr && !otherRstSrc) |=> (sysRstReq && !extRstOut));

  // R3
  rdata_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdata[DATA_W-1] == 1'b0) && (busRdata[DATA_W-3:0] == '0));

  // R6
  rdata_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == REG_OFFSET) |-> (busRdata[DATA_W-2] == extRstOut));

endmodule

bind swrst_ctl_reg swrst_ctl_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .otherRstSrc(otherRstSrc),
  .sysRstReq(sysRstReq), .extRstOut(extRstOut)
);

// File: tb/swrst_ctl_reg_tb.sv
module swrst_ctl_reg_tb;

  localparam int PULSE = 2400;
  localparam logic [7:0] OFF = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        otherRstSrc = 1'b0;
  logic        sysRstReq;
  logic        extRstOut;

  always #4 clk = ~clk;

  swrst_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .otherRstSrc(otherRstSrc),
    .sysRstReq(sysRstReq), .extRstOut(extRstOut)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // Behavioural reference: remaining pulse cycles and a system-request flag.
  int mRem = 0;
  bit mSys = 1'b0;
  int highRun = 0;
  int lastRun = 0;
  int sysCount = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit hit;
    hit = busWe && (busAddr == OFF);
    if (!rst_n) begin
      mRem <= 0;
      mSys <= 1'b0;
    end else if (otherRstSrc) begin
      mRem <= 0;
      mSys <= 1'b0;
    end else if (hit && busWdata[31]) begin
      mSys <= 1'b1;
      mRem <= 0;
    end else begin
      mSys <= 1'b0;
      if (hit && busWdata[30] && mRem == 0) mRem <= PULSE;
      else if (mRem > 0) mRem <= mRem - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({curReq, " sysRstReq"}, {31'b0, sysRstReq}, {31'b0, mSys});
      check({curReq, " extRstOut"}, {31'b0, extRstOut}, {31'b0, (mRem > 0)});
      check({curReq, " busRdata"}, busRdata,
            (busAddr == OFF) ? {1'b0, (mRem > 0), 30'b0} : 32'h0);
      if (extRstOut) highRun++;
      else begin
        if (highRun > 0) lastRun = highRun;
        highRun = 0;
      end
      if (sysRstReq) sysCount++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk) #1;
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk) #1;
    busWe = 1'b0; busWdata = 32'h0; busAddr = OFF;
  endtask

  initial begin
    int s0;
    // R1: reset state
    busAddr = OFF;
    idle(3);
    #2;
    check("R1 reset sysRstReq", {31'b0, sysRstReq}, 32'h0);
    check("R1 reset extRstOut", {31'b0, extRstOut}, 32'h0);
    check("R1 reset busRdata", busRdata, 32'h0);
    @(posedge clk) #1 rst_n = 1'b1;
    idle(3);

    // R2: other addresses ignored
    curReq = "R2";
    wr(8'h14, 32'h4000_0000);
    wr(8'h00, 32'h8000_0000);
    idle(4);
    check("R2 no pulse from wrong address", {31'b0, extRstOut}, 32'h0);

    // R5/R6: full pulse with readback
    curReq = "R5/R6";
    wr(OFF, 32'h4000_0000);
    idle(PULSE + 4);
    check("R5 pulse length", lastRun, PULSE);

    // R2: reading elsewhere during a pulse returns 0
    curReq = "R2";
    wr(OFF, 32'h4000_0000);
    @(posedge clk) #1 busAddr = 8'h14;
    idle(200);
    @(posedge clk) #1 busAddr = OFF;
    idle(PULSE);

    // R4: one-cycle system request
    curReq = "R4";
    s0 = sysCount;
    wr(OFF, 32'h8000_0000);
    idle(4);
    check("R4 system request cycles", sysCount - s0, 1);

    // R7 and R9: zero writes and re-trigger during a pulse
    curReq = "R7";
    wr(OFF, 32'h0000_0000);
    idle(3);
    wr(OFF, 32'h4000_0000);
    idle(100);
    wr(OFF, 32'h0000_0000);
    wr(OFF, 32'h3FFF_FFFF);
    idle(400);
    curReq = "R9";
    wr(OFF, 32'h4000_0000);
    idle(PULSE);
    check("R9 no extension", lastRun, PULSE);

    // R8: other reset source aborts a pulse and cancels a same-cycle write
    curReq = "R8";
    wr(OFF, 32'h4000_0000);
    idle(50);
    @(posedge clk) #1;
    otherRstSrc = 1'b1; busWe = 1'b1; busWdata = 32'h8000_0000;
    @(posedge clk) #1;
    otherRstSrc = 1'b0; busWe = 1'b0; busWdata = 32'h0;
    #2;
    check("R8 abort extRstOut", {31'b0, extRstOut}, 32'h0);
    check("R8 cancelled sysRstReq", {31'b0, sysRstReq}, 32'h0);
    @(posedge clk) #1;
    otherRstSrc = 1'b1; busWe = 1'b1; busWdata = 32'h4000_0000;
    @(posedge clk) #1;
    otherRstSrc = 1'b0; busWe = 1'b0; busWdata = 32'h0;
    idle(5);
    check("R8 no pulse started", {31'b0, extRstOut}, 32'h0);

    // R10: both bits, idle and during a pulse
    curReq = "R10";
    wr(OFF, 32'hC000_0000);
    idle(5);
    check("R10 idle both bits no pulse", {31'b0, extRstOut}, 32'h0);
    wr(OFF, 32'h4000_0000);
    idle(30);
    wr(OFF, 32'hC000_0000);
    #2;
    check("R10 running pulse ended", {31'b0, extRstOut}, 32'h0);
    check("R10 system raised", {31'b0, sysRstReq}, 32'h1);
    idle(5);

    // R3: bit numbering and reserved bits
    curReq = "R3";
    wr(OFF, 32'h0000_0003);
    idle(3);
    check("R3 low bits ignored", {31'b0, extRstOut}, 32'h0);
    wr(OFF, 32'hFFFF_FFFF);
    idle(3);
    wr(OFF, 32'h7FFF_FFFF);
    idle(10);
    #2;
    check("R3 reserved read zero", busRdata, 32'h4000_0000);
    idle(PULSE);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule